// File: doc/BRIEF.md
# Comparator Change-Interrupt Flag Logic

This block watches the already-synchronised digital outputs of two comparators. It raises one interrupt flag per comparator whenever the live output differs from a snapshot. The snapshot is refreshed only when the processor reads or writes the comparator status register. While the live value and the snapshot disagree, the flag is forced back to 1 on every clock. Software therefore has to touch the status register first, and only then can it clear the flag by writing 0.

A small register port with one-cycle access gives the processor four registers:

- the live comparator status,
- the flag register,
- the per-source enable register,
- a control register holding the peripheral enable and the global enable.

Software may also write a 1 into a flag bit to trigger an interrupt deliberately. The single interrupt request line is registered. It is the OR of the enabled flags, gated by both the peripheral enable and the global enable. The flags keep setting even when any of the enables is 0.

Top module: `cmpint_top`

## Requirements
- R1: After a synchronous active-low reset, all flags, per-source enables, the peripheral enable, the global enable and `irq` are 0. The snapshot is loaded from the live comparator inputs, so a nonzero input present during reset raises no flag.
- R2: Address 0 is the status register. It reads comparator 1 at bit 7 and comparator 0 at bit 6, taken live from `cmp_in`, and all other bits read 0. A write to it changes no stored value.
- R3: When comparator i's input differs from its snapshot, flag i (address 1, bit 5+i) is 1 after the next rising clock edge.
- R4: While that mismatch persists, writing 0 to the flag bit does not clear it, because the flag is re-set on every clock.
- R5: Any read or write of address 0 copies the live inputs into the snapshot at that clock edge. A later write of 0 to the flag bit then clears it.
- R6: Writing 1 to a flag bit sets it with no comparator change, and this drives `irq` when the flag is enabled.
- R7: When a flag write of 0 and a new mismatch on the same comparator occur in the same cycle, the flag ends up 1.
- R8: `irq` is registered. It is 1 one cycle after global enable AND peripheral enable AND (any flag i AND enable i) hold, and 0 one cycle after that condition is false. Flags still set while `irq` is masked.
- R9: Address 2 holds the per-source enables at bits 6:5. Address 3 holds the global enable at bit 7 and the peripheral enable at bit 6. All other bits of both registers ignore writes and read 0.
- R10: The two flags are independent: a change on one comparator, or a flag write affecting one bit, leaves the other flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | 2 | Synchronised comparator outputs, bit i = comparator i |
| addr | input | 2 | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench tries to clear a flag while the mismatch is still live. A design that let the clear through would read the flag as 0 instead of 1.

It makes the same-cycle clear and new change collide on two comparators together. A design that gave priority to the clear, or that mixed up the channels, would show the wrong flag pattern.

It checks the refresh through both the read path and the write path of the status register. It also sets flags while the enables are off. A design that masked the flag itself, or that put `irq` on the wrong cycle, would fail against the reference model, which is compared on every clock together with a stretch of random traffic.

// File: rtl/cmpint_pkg.sv
package cmpint_pkg;
  // Register addresses
  localparam int unsigned ADDR_STAT = 0;
  localparam int unsigned ADDR_FLAG = 1;
  localparam int unsigned ADDR_EN   = 2;
  localparam int unsigned ADDR_CTRL = 3;

  // Next flag state: a live mismatch outranks any software write
  function automatic logic flag_next(input logic mism, input logic wr_hit,
                                     input logic wbit, input logic cur);
    logic r;
    if (mism)        r = 1'b1;
    else if (wr_hit) r = wbit;
    else             r = cur;
    return r;
  endfunction

  // Request term: both enables and at least one enabled flag
  function automatic logic irq_term(input logic gie, input logic peie,
                                    input logic any_enabled);
    return gie & peie & any_enabled;
  endfunction
endpackage

// File: rtl/cmpint_chan.sv
module cmpint_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp,
  input  logic refresh,
  input  logic flag_wr,
  input  logic wbit,
  output logic flag,
  output logic snap,
  output logic mismatch
);
  import cmpint_pkg::*;

  assign mismatch = cmp ^ snap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap <= cmp;
      flag <= 1'b0;
    end else begin
      if (refresh) snap <= cmp;
      flag <= flag_next(mismatch, flag_wr, wbit, flag);
    end
  end
endmodule

// File: rtl/cmpint_regs.sv
module cmpint_regs #(
  parameter int unsigned N_CMP    = 2,
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 2,
  parameter int unsigned STAT_LSB = 6,
  parameter int unsigned FLAG_LSB = 5,
  parameter int unsigned EN_LSB   = 5,
  parameter int unsigned GIE_BIT  = 7,
  parameter int unsigned PEIE_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic [N_CMP-1:0] cmp_in,
  input  logic [N_CMP-1:0] flags,
  output logic             stat_access,
  output logic             flag_wr,
  output logic [N_CMP-1:0] en_q,
  output logic             gie_q,
  output logic             peie_q,
  output logic [DW-1:0]    rdata
);
  import cmpint_pkg::*;

  localparam logic [AW-1:0] A_STAT = AW'(ADDR_STAT);
  localparam logic [AW-1:0] A_FLAG = AW'(ADDR_FLAG);
  localparam logic [AW-1:0] A_EN   = AW'(ADDR_EN);
  localparam logic [AW-1:0] A_CTRL = AW'(ADDR_CTRL);

  logic en_wr, ctrl_wr;

  assign stat_access = (rd_en | wr_en) && (addr == A_STAT);
  assign flag_wr     = wr_en && (addr == A_FLAG);
  assign en_wr       = wr_en && (addr == A_EN);
  assign ctrl_wr     = wr_en && (addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      gie_q  <= 1'b0;
      peie_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= wdata[EN_LSB +: N_CMP];
      if (ctrl_wr) begin
        gie_q  <= wdata[GIE_BIT];
        peie_q <= wdata[PEIE_BIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_STAT: rdata[STAT_LSB +: N_CMP] = cmp_in;
      A_FLAG: rdata[FLAG_LSB +: N_CMP] = flags;
      A_EN:   rdata[EN_LSB +: N_CMP]   = en_q;
      A_CTRL: begin
        rdata[GIE_BIT]  = gie_q;
        rdata[PEIE_BIT] = peie_q;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmpint_irq.sv
module cmpint_irq #(
  parameter int unsigned N_CMP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CMP-1:0] flags,
  input  logic [N_CMP-1:0] en,
  input  logic             gie,
  input  logic             peie,
  output logic             irq
);
  import cmpint_pkg::*;

  logic any_enabled;
  assign any_enabled = |(flags & en);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_term(gie, peie, any_enabled);
  end
endmodule

// File: rtl/cmpint_top.sv
module cmpint_top #(
  parameter int unsigned N_CMP    = 2,
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 2,
  parameter int unsigned STAT_LSB = 6,
  parameter int unsigned FLAG_LSB = 5,
  parameter int unsigned EN_LSB   = 5,
  parameter int unsigned GIE_BIT  = 7,
  parameter int unsigned PEIE_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CMP-1:0] cmp_in,
  input  logic [AW-1:0]    addr,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq
);
  // Internal events brought out for the checker
  logic [N_CMP-1:0] flag_q;
  logic [N_CMP-1:0] snap_q;
  logic [N_CMP-1:0] mismatch_w;
  logic [N_CMP-1:0] en_q;
  logic             gie_q, peie_q;
  logic             stat_access_w, flag_wr_w;

  cmpint_regs #(
    .N_CMP(N_CMP), .DW(DW), .AW(AW), .STAT_LSB(STAT_LSB), .FLAG_LSB(FLAG_LSB),
    .EN_LSB(EN_LSB), .GIE_BIT(GIE_BIT), .PEIE_BIT(PEIE_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .cmp_in(cmp_in), .flags(flag_q),
    .stat_access(stat_access_w), .flag_wr(flag_wr_w), .en_q(en_q),
    .gie_q(gie_q), .peie_q(peie_q), .rdata(rdata)
  );

  for (genvar i = 0; i < N_CMP; i++) begin : g_chan
    cmpint_chan u_chan (
      .clk(clk), .rst_n(rst_n), .cmp(cmp_in[i]), .refresh(stat_access_w),
      .flag_wr(flag_wr_w), .wbit(wdata[FLAG_LSB + i]),
      .flag(flag_q[i]), .snap(snap_q[i]), .mismatch(mismatch_w[i])
    );
  end

  cmpint_irq #(.N_CMP(N_CMP)) u_irq (
    .clk(clk), .rst_n(rst_n), .flags(flag_q), .en(en_q),
    .gie(gie_q), .peie(peie_q), .irq(irq)
  );
endmodule

// File: rtl/cmpint_chk.sv
module cmpint_chk #(
  parameter int unsigned N_CMP = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_CMP-1:0] cmp_in,
  input logic [N_CMP-1:0] flags,
  input logic [N_CMP-1:0] snap,
  input logic [N_CMP-1:0] mismatch,
  input logic [N_CMP-1:0] en,
  input logic             gie,
  input logic             peie,
  input logic             stat_access,
  input logic             flag_wr,
  input logic             irq
);
  for (genvar i = 0; i < N_CMP; i++) begin : g_bit
    // R4 and R7: a mismatch always leaves the flag set
    p_mismatch_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch[i] |=> flags[i]);
    // R3: with no mismatch and no flag write, the flag holds
    p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mismatch[i] && !flag_wr) |=> $stable(flags[i]));
  end

  // R5: a status access refreshes the snapshot
  p_snap_refresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_access |=> (snap == $past(cmp_in)));

  // R8: the request is masked while either enable is low
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gie && peie) |=> !irq);

  // R8: a request always has an enabled flag behind it
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gie && peie && ((flags & en) != '0)));
endmodule

bind cmpint_top cmpint_chk #(.N_CMP(N_CMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .flags(flag_q), .snap(snap_q),
  .mismatch(mismatch_w), .en(en_q), .gie(gie_q), .peie(peie_q),
  .stat_access(stat_access_w), .flag_wr(flag_wr_w), .irq(irq)
);

// File: tb/cmpint_top_tb.sv
module cmpint_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmp_in = 2'b10;
  logic [1:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // Behavioural reference state
  int m_snap[2], m_flag[2], m_en[2];
  int m_gie, m_peie, m_irq;

  always #4 clk = ~clk;  // 125 MHz

  cmpint_top u_dut (.clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int nirq;
    nirq = 0;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_snap[i] = cmp_in[i]; m_flag[i] = 0; m_en[i] = 0;
      end
      m_gie = 0; m_peie = 0; m_irq = 0;
      return;
    end
    for (int i = 0; i < 2; i++) if (m_flag[i] != 0 && m_en[i] != 0) nirq = 1;
    if (m_gie == 0 || m_peie == 0) nirq = 0;
    for (int i = 0; i < 2; i++) begin
      if (cmp_in[i] != m_snap[i]) m_flag[i] = 1;
      else if (wr_en && addr == 1) m_flag[i] = wdata[5+i];
    end
    if (wr_en && addr == 2) for (int i = 0; i < 2; i++) m_en[i] = wdata[5+i];
    if (wr_en && addr == 3) begin m_gie = wdata[7]; m_peie = wdata[6]; end
    if ((rd_en || wr_en) && addr == 0) for (int i = 0; i < 2; i++) m_snap[i] = cmp_in[i];
    m_irq = nirq;
  endtask

  function automatic int exp_rdata();
    case (addr)
      2'd0: return cmp_in[1] * 128 + cmp_in[0] * 64;
      2'd1: return m_flag[1] * 64 + m_flag[0] * 32;
      2'd2: return m_en[1] * 64 + m_en[0] * 32;
      default: return m_gie * 128 + m_peie * 64;
    endcase
  endfunction

  // One clock: model advances at the edge, outputs compared at the falling edge
  task automatic tick();
    string t;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R8 irq vs model", int'(irq), m_irq);
    t = (addr == 0) ? "R2 status vs model" : (addr == 1) ? "R3 flags vs model" : "R9 enables vs model";
    chk(t, int'(rdata), exp_rdata());
  endtask

  task automatic op(bit r, bit w, int a, int d);
    rd_en = r; wr_en = w; addr = 2'(a); wdata = 8'(d);
    tick();
    rd_en = 0; wr_en = 0;
  endtask

  task automatic rd_chk(int a, int exp, string tag);
    rd_en = 1; addr = 2'(a);
    #1 chk(tag, int'(rdata), exp);
    tick();
    rd_en = 0;
  endtask

  initial begin
    @(negedge clk);
    tick(); tick();
    rst_n = 1;
    tick();
    // R1: reset state, nonzero input present during reset
    rd_chk(1, 8'h00, "R1 flags clear after reset");
    chk("R1 irq low after reset", int'(irq), 0);
    rd_chk(2, 8'h00, "R1 enables clear after reset");
    rd_chk(3, 8'h00, "R1 control clear after reset");
    // R2: live status at bits 7:6
    rd_chk(0, 8'h80, "R2 status reads live inputs");
    // R3 and R10: a change on comparator 0 only
    cmp_in = 2'b11; op(0, 0, 1, 0);
    rd_chk(1, 8'h20, "R3 flag0 set, R10 flag1 untouched");
    // R4: a clear during the mismatch is overridden
    op(0, 1, 1, 8'h00);
    rd_chk(1, 8'h20, "R4 clear ignored during mismatch");
    // R5: refresh by reading, then clear
    op(1, 0, 0, 0);
    op(0, 1, 1, 8'h00);
    rd_chk(1, 8'h00, "R5 clear after status read");
    // R7: clear and new change in the same cycle
    cmp_in = 2'b01; op(0, 0, 1, 0);
    op(1, 0, 0, 0);
    cmp_in = 2'b00; op(0, 1, 1, 8'h00);
    rd_chk(1, 8'h20, "R7 set wins, R10 flag1 cleared");
    // R8: masking and one-cycle latency
    op(0, 1, 2, 8'h20);
    op(0, 1, 3, 8'h40);
    op(0, 0, 1, 0);
    chk("R8 irq masked by global enable", int'(irq), 0);
    op(0, 1, 3, 8'hC0);
    chk("R8 irq not yet high", int'(irq), 0);
    op(0, 0, 1, 0);
    chk("R8 irq high one cycle later", int'(irq), 1);
    op(1, 0, 0, 0);
    op(0, 1, 1, 8'h00);
    op(0, 0, 1, 0);
    chk("R8 irq low after flag cleared", int'(irq), 0);
    // R6: simulated interrupt by writing 1
    op(0, 1, 1, 8'h40);
    rd_chk(1, 8'h40, "R6 flag1 set by software");
    chk("R6 irq stays low, flag1 not enabled", int'(irq), 0);
    op(0, 1, 2, 8'h60);
    op(0, 0, 1, 0);
    chk("R6 irq from software flag", int'(irq), 1);
    // R9: unused bits ignored
    op(0, 1, 2, 8'hFF);
    rd_chk(2, 8'h60, "R9 enable register bits");
    op(0, 1, 3, 8'hFF);
    rd_chk(3, 8'hC0, "R9 control register bits");
    // R5 and R2: refresh by a write to the status register
    op(0, 1, 1, 8'h00);
    cmp_in = 2'b10; op(0, 1, 0, 8'hFF);
    rd_chk(0, 8'h80, "R2 status write stores nothing");
    op(0, 1, 1, 8'h00);
    rd_chk(1, 8'h00, "R5 clear after status write");
    // R8: flags set while masked
    op(0, 1, 3, 8'h00);
    cmp_in = 2'b01; op(0, 0, 1, 0);
    rd_chk(1, 8'h60, "R8 flags set while masked");
    chk("R8 irq low while masked", int'(irq), 0);
    // Random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 3) == 0) cmp_in = 2'($urandom);
      op(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 2) == 0),
         int'($urandom_range(0, 3)), int'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule